// File: doc/BRIEF.md
# Shared-Generator PWM Bank

This block drives sixteen output pins from a pool of eight waveform generators. Each generator is set up with a coarse period and an on-count on a fixed 255-step scale. Each output channel holds a routing nibble that names one generator and carries an enable bit. Several channels can point at one generator and then toggle in lockstep. This allows many pins to blink or dim while only eight distinct waveforms need hardware.

Software configures the bank through a one-cycle write strobe with a word address and a 32-bit data word. Period and on-count changes take effect on the next clock. Clearing a channel's enable is held back until the selected generator finishes its current period, so a pin never ends on a truncated pulse. A shared prescaler sets the base time unit. In the target system that unit is 4 ms divided by 255; in the bench it is `TICK_DIV` clocks.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every channel output is low and every channel is disabled. All configuration words reset to zero.
- R2: Word addresses and field positions are fixed:
  - Words 0 and 1 hold the periods, four per word. Generator g uses bits [8*(g%4)+7 : 8*(g%4)] of word g/4.
  - Words 2 to 5 hold the timing words, two per word. Generator g uses bits [16*(g%2)+15 : 16*(g%2)] of word 2+g/2. The low byte of each 16-bit field is the on-count and the high byte (off-count) is not used by the hardware.
  - Words 6 and 7 hold the channel map, eight nibbles per word. Channel c uses the nibble at bits [4*(c%8)+3 : 4*(c%8)] of word 6+c/8. In that nibble, bits [2:0] select the generator and bit 3 is the enable.
- R3: A generator with period P and on-count D repeats every 255·P·TICK_DIV clocks. In each repetition it is high for D·P·TICK_DIV clocks and then low for the rest.
- R4: An on-count of 0 gives a constant low. An on-count of 255 gives a constant high.
- R5: A period value of 0 is treated as 1. A period value above 250 is treated as 250.
- R6: A write of a new on-count or period reaches the outputs in the cycle after the write. It does not wait for the current period to end.
- R7: An enabled channel copies its selected generator. Channels that share a generator are identical. A disabled channel is low, whatever its generator does.
- R8: A map write that sets the enable or changes the generator selection takes effect in the cycle after the write.
- R9: A map write that clears the enable leaves the channel following its generator until that generator's next period wrap, and then the channel goes low. A clear that lands on the wrap edge itself takes effect at that wrap.
- R10: Setting the enable again before the wrap cancels a pending disable, and the channel keeps following its generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per word |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| ch_out | output | 16 | Channel output levels |

## Verification
Two events can land in the same clock: a map write that clears a channel's enable, and the period wrap of the generator that channel follows. The bench locks onto a rising edge of a reference channel on the same generator and counts exactly one period of clocks. It then aims the clearing write at the wrap edge itself, and in a second run at the edge one clock after it. In the first run the channel must already be low while the reference channel is high. In the second run the channel must keep exactly the rest of the new high pulse and then stay low.

// File: rtl/pwm_bank_pkg.sv
// Package pwm_bank_pkg
// Shared constants and the channel map nibble type for the PWM bank.
// Assumes a 32-bit configuration word and a fixed 255-step duty scale.
package pwm_bank_pkg;

    localparam int CFG_DATA_W      = 32;
    localparam int PERIOD_FIELD_W  = 8;
    localparam int TIMING_FIELD_W  = 16;
    localparam int COUNT_W         = 8;
    localparam int MAP_FIELD_W     = 4;
    localparam int SEL_W           = 3;
    localparam int STEP_COUNT      = 255;
    localparam int PERIOD_LIMIT    = 250;

    localparam int PERIODS_PER_WORD = CFG_DATA_W / PERIOD_FIELD_W;
    localparam int TIMINGS_PER_WORD = CFG_DATA_W / TIMING_FIELD_W;
    localparam int MAPS_PER_WORD    = CFG_DATA_W / MAP_FIELD_W;
    localparam int SEL_SLOTS        = 1 << SEL_W;

    // Routing nibble: enable in the top bit, generator index below it
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] gen;
    } chan_map_t;

endpackage

// File: rtl/pwm_tick_prescaler.sv
// Module pwm_tick_prescaler
// Divides the clock down to the base time unit shared by all generators.
// Emits a one-cycle tick every TICK_DIV clocks; TICK_DIV of 1 ticks every cycle.
module pwm_tick_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
            logic [CW-1:0] cnt_q;

            // Free-running divider that restarts after the last count
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/pwm_wave_gen.sv
// Module pwm_wave_gen
// One waveform generator. Each period is split into STEP_COUNT equal steps.
// A step lasts PERIOD base ticks, where PERIOD is the clamped period value.
// The output is high while the step index is below the on-count.
// Assumes the on-count and period inputs are registered upstream. A change to
// either acts on the next clock.
module pwm_wave_gen
    import pwm_bank_pkg::*;
#(
    parameter int STEPS      = STEP_COUNT,
    parameter int PERIOD_MAX = PERIOD_LIMIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [COUNT_W-1:0] period_raw,
    input  logic [COUNT_W-1:0] on_count,
    output logic               wave,
    output logic               wrap,
    output logic [COUNT_W-1:0] step,
    output logic [COUNT_W-1:0] sub
);

    localparam logic [COUNT_W-1:0] STEP_LAST = COUNT_W'(STEPS - 1);
    localparam logic [COUNT_W-1:0] PMAX      = COUNT_W'(PERIOD_MAX);

    logic [COUNT_W-1:0] period_eff;
    logic [COUNT_W-1:0] sub_q;
    logic [COUNT_W-1:0] step_q;
    logic               sub_last;
    logic               step_last;

    // Clamp the programmed period into the legal range
    always_comb begin
        if (period_raw == '0) begin
            period_eff = COUNT_W'(1);
        end else if (period_raw > PMAX) begin
            period_eff = PMAX;
        end else begin
            period_eff = period_raw;
        end
    end

    // ">=" lets a period that has just shrunk finish its step at once
    assign sub_last  = (sub_q >= (period_eff - 1'b1));
    assign step_last = (step_q == STEP_LAST);

    // Count base ticks within a step, then advance the step index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            step_q <= '0;
        end else if (tick) begin
            if (sub_last) begin
                sub_q  <= '0;
                step_q <= step_last ? '0 : step_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign wrap = tick & sub_last & step_last;
    assign wave = (step_q < on_count);
    assign step = step_q;
    assign sub  = sub_q;

endmodule

// File: rtl/pwm_channel_router.sv
// Module pwm_channel_router
// Holds a routing nibble for each channel and selects the generator output.
// Setting the enable acts at once. Clearing it leaves the channel following
// its generator until that generator's next period wrap.
// Assumes map_we is a decoded per-word strobe aligned with wr_data.
module pwm_channel_router
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN   = 8,
    parameter int NUM_CH    = 16,
    parameter int MAP_WORDS = NUM_CH / MAPS_PER_WORD
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [MAP_WORDS-1:0]          map_we,
    input  logic [CFG_DATA_W-1:0]         wr_data,
    input  logic [NUM_GEN-1:0]            gen_wave,
    input  logic [NUM_GEN-1:0]            gen_wrap,
    output logic [NUM_CH-1:0]             ch_out,
    output logic [NUM_CH-1:0]             en_eff,
    output logic [NUM_CH-1:0][SEL_W-1:0]  ch_sel
);

    logic [SEL_SLOTS-1:0] wave_pad;
    logic [SEL_SLOTS-1:0] wrap_pad;

    assign wave_pad = SEL_SLOTS'(gen_wave);
    assign wrap_pad = SEL_SLOTS'(gen_wrap);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int WORD = c / MAPS_PER_WORD;
            localparam int LSB  = (c % MAPS_PER_WORD) * MAP_FIELD_W;

            chan_map_t  nib;
            logic       en_req_q;

            assign nib = chan_map_t'(wr_data[LSB +: MAP_FIELD_W]);

            // Update selection and requested enable; retire a disable at wrap
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ch_sel[c] <= '0;
                    en_req_q  <= 1'b0;
                    en_eff[c] <= 1'b0;
                end else if (map_we[WORD]) begin
                    ch_sel[c] <= nib.gen;
                    en_req_q  <= nib.en;
                    en_eff[c] <= nib.en | (en_eff[c] & ~wrap_pad[nib.gen]);
                end else begin
                    en_eff[c] <= en_req_q | (en_eff[c] & ~wrap_pad[ch_sel[c]]);
                end
            end

            // Gate the selected generator with the effective enable
            assign ch_out[c] = en_eff[c] & wave_pad[ch_sel[c]];
        end
    endgenerate

endmodule

// File: rtl/pwm_bank.sv
// Module pwm_bank
// Top of the shared-generator PWM bank. It decodes configuration writes into
// the period and on-count registers, runs NUM_GEN generators from one
// prescaler, and routes them to NUM_CH channel outputs.
// Word map: period words first, then timing words, then map words.
// Assumes NUM_GEN is a multiple of 4, NUM_GEN is at most 8, and NUM_CH is a
// multiple of 8.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_CH   = 16,
    parameter int TICK_DIV = 4,
    localparam int PER_WORDS = NUM_GEN / PERIODS_PER_WORD,
    localparam int TIM_WORDS = NUM_GEN / TIMINGS_PER_WORD,
    localparam int MAP_WORDS = NUM_CH / MAPS_PER_WORD,
    localparam int ADDR_W    = $clog2(PER_WORDS + TIM_WORDS + MAP_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CFG_DATA_W-1:0] wr_data,
    output logic [NUM_CH-1:0]     ch_out
);

    localparam int PER_BASE = 0;
    localparam int TIM_BASE = PER_WORDS;
    localparam int MAP_BASE = PER_WORDS + TIM_WORDS;

    logic                              tick;
    logic [NUM_GEN-1:0][COUNT_W-1:0]   period_q;
    logic [NUM_GEN-1:0][COUNT_W-1:0]   on_q;
    logic [NUM_GEN-1:0]                gen_wave;
    logic [NUM_GEN-1:0]                gen_wrap;
    logic [NUM_GEN-1:0][COUNT_W-1:0]   gen_step;
    logic [NUM_GEN-1:0][COUNT_W-1:0]   gen_sub;
    logic [MAP_WORDS-1:0]              map_we;
    logic [NUM_CH-1:0]                 ch_en_eff;
    logic [NUM_CH-1:0][SEL_W-1:0]      ch_sel;

    pwm_tick_prescaler #(
        .TICK_DIV (TICK_DIV)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
            localparam int PW  = PER_BASE + g / PERIODS_PER_WORD;
            localparam int PL  = (g % PERIODS_PER_WORD) * PERIOD_FIELD_W;
            localparam int TW  = TIM_BASE + g / TIMINGS_PER_WORD;
            localparam int TL  = (g % TIMINGS_PER_WORD) * TIMING_FIELD_W;

            // Capture this generator's period field on a write to its word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    period_q[g] <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(PW))) begin
                    period_q[g] <= wr_data[PL +: COUNT_W];
                end
            end

            // Capture the on-count (low byte of the timing field)
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    on_q[g] <= '0;
                end else if (wr_en && (wr_addr == ADDR_W'(TW))) begin
                    on_q[g] <= wr_data[TL +: COUNT_W];
                end
            end

            pwm_wave_gen u_gen (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .period_raw (period_q[g]),
                .on_count   (on_q[g]),
                .wave       (gen_wave[g]),
                .wrap       (gen_wrap[g]),
                .step       (gen_step[g]),
                .sub        (gen_sub[g])
            );
        end

        for (genvar w = 0; w < MAP_WORDS; w++) begin : g_mapdec
            // Decode a write strobe for each channel map word
            assign map_we[w] = wr_en && (wr_addr == ADDR_W'(MAP_BASE + w));
        end
    endgenerate

    pwm_channel_router #(
        .NUM_GEN   (NUM_GEN),
        .NUM_CH    (NUM_CH),
        .MAP_WORDS (MAP_WORDS)
    ) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_we   (map_we),
        .wr_data  (wr_data),
        .gen_wave (gen_wave),
        .gen_wrap (gen_wrap),
        .ch_out   (ch_out),
        .en_eff   (ch_en_eff),
        .ch_sel   (ch_sel)
    );

endmodule

// File: rtl/pwm_bank_checker.sv
// Module pwm_bank_checker
// Property checks for pwm_bank, attached by the bind statement at the end
// of this file. Only observes; drives nothing into the design.
module pwm_bank_checker
    import pwm_bank_pkg::*;
#(
    parameter int NUM_GEN = 8,
    parameter int NUM_CH  = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_CH-1:0]                ch_out,
    input logic [NUM_CH-1:0]                ch_en_eff,
    input logic [NUM_CH-1:0][SEL_W-1:0]     ch_sel,
    input logic [NUM_GEN-1:0]               gen_wave,
    input logic [NUM_GEN-1:0]               gen_wrap,
    input logic [NUM_GEN-1:0][COUNT_W-1:0]  gen_step,
    input logic [NUM_GEN-1:0][COUNT_W-1:0]  gen_sub,
    input logic [NUM_GEN-1:0][COUNT_W-1:0]  on_q
);

    logic [SEL_SLOTS-1:0] wrap_q;
    logic [SEL_SLOTS-1:0] wave_pad;

    assign wave_pad = SEL_SLOTS'(gen_wave);

    // Remember last cycle's wrap pulses for the deferred-disable check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_q <= '0;
        end else begin
            wrap_q <= SEL_SLOTS'(gen_wrap);
        end
    end

    assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ch_out == '0));

    generate
        for (genvar g = 0; g < NUM_GEN; g++) begin : g_gchk
            assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
                gen_step[g] <= COUNT_W'(STEP_COUNT - 1));

            assert_full_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (on_q[g] == COUNT_W'(STEP_COUNT)) |-> gen_wave[g]);

            assert_period_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
                gen_sub[g] < COUNT_W'(PERIOD_LIMIT));
        end

        for (genvar c = 0; c < NUM_CH; c++) begin : g_cchk
            assert_follow_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ch_out[c] |-> (ch_en_eff[c] && wave_pad[ch_sel[c]]));

            assert_disable_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(ch_en_eff[c]) |-> wrap_q[ch_sel[c]]);
        end
    endgenerate

endmodule

bind pwm_bank pwm_bank_checker #(
    .NUM_GEN (NUM_GEN),
    .NUM_CH  (NUM_CH)
) u_pwm_bank_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_out    (ch_out),
    .ch_en_eff (ch_en_eff),
    .ch_sel    (ch_sel),
    .gen_wave  (gen_wave),
    .gen_wrap  (gen_wrap),
    .gen_step  (gen_step),
    .gen_sub   (gen_sub),
    .on_q      (on_q)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NUM_GEN    = 8;
    localparam int NUM_CH     = 16;
    localparam int STEPS      = 255;
    localparam int WATCHDOG   = 190000;
    localparam int FULL_P1    = STEPS * TICK_DIV;

    logic        clk;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [NUM_CH-1:0] ch_out;

    int n_checks;
    int n_fail;
    logic [31:0] shadow [8];

    pwm_bank #(
        .NUM_GEN  (NUM_GEN),
        .NUM_CH   (NUM_CH),
        .TICK_DIV (TICK_DIV)
    ) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ch_out  (ch_out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (R3) actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge, returns at the following negedge
    task automatic write_word(input int addr, input logic [31:0] data);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_period(input int g, input int p);
        shadow[g / 4][8 * (g % 4) +: 8] = 8'(p);
        write_word(g / 4, shadow[g / 4]);
    endtask

    task automatic set_duty(input int g, input int d);
        shadow[2 + g / 2][16 * (g % 2) +: 16] = {8'(STEPS - d), 8'(d)};
        write_word(2 + g / 2, shadow[2 + g / 2]);
    endtask

    task automatic set_map(input int c, input int g, input bit en);
        shadow[6 + c / 8][4 * (c % 8) +: 4] = {en, 3'(g)};
        write_word(6 + c / 8, shadow[6 + c / 8]);
    endtask

    task automatic wait_rise(input int c);
        logic prev;
        prev = ch_out[c];
        forever begin
            @(negedge clk);
            if (!prev && ch_out[c]) break;
            prev = ch_out[c];
        end
    endtask

    task automatic measure(input int c, output int hi, output int lo);
        wait_rise(c);
        hi = 0;
        while (ch_out[c]) begin hi++; @(negedge clk); end
        lo = 0;
        while (!ch_out[c]) begin lo++; @(negedge clk); end
    endtask

    task automatic count_high(input int c, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ch_out[c]) hi++;
        end
    endtask

    function automatic int exp_hi(input int d, input int p);
        int pe;
        pe = (p == 0) ? 1 : (p > 250 ? 250 : p);
        return d * pe * TICK_DIV;
    endfunction

    function automatic int exp_lo(input int d, input int p);
        int pe;
        pe = (p == 0) ? 1 : (p > 250 ? 250 : p);
        return (STEPS - d) * pe * TICK_DIV;
    endfunction

    initial begin
        int hi, lo, hi2, mism, g, c, p, d;
        n_checks = 0;
        n_fail   = 0;
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        void'($urandom(32'h5EED_0042));
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        check_eq("R1 outputs low in reset", int'(ch_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 outputs low after release", int'(ch_out), 0);

        // R7: disabled channel stays low while its generator is full on
        set_duty(0, 255);
        count_high(0, 300, hi);
        check_eq("R7 disabled channel low", hi, 0);

        // R8: enable acts the cycle after the write
        set_map(0, 0, 1'b1);
        check_eq("R8 enable immediate", int'(ch_out[0]), 1);

        // R4: full duty constant high, zero duty constant low
        count_high(0, 1100, hi);
        check_eq("R4 duty 255 constant high", hi, 1100);
        set_duty(1, 0);
        set_map(1, 1, 1'b1);
        count_high(1, 1100, hi);
        check_eq("R4 duty 0 constant low", hi, 0);

        // R8: selection change acts at once
        set_map(0, 1, 1'b1);
        check_eq("R8 reselect to low generator", int'(ch_out[0]), 0);
        set_map(0, 0, 1'b1);
        check_eq("R8 reselect to high generator", int'(ch_out[0]), 1);

        // R6: on-count change acts at once
        set_duty(0, 0);
        check_eq("R6 duty drop immediate", int'(ch_out[0]), 0);
        set_duty(0, 255);
        check_eq("R6 duty raise immediate", int'(ch_out[0]), 1);

        // R2: field packing for generator 5 and channel 13
        set_period(5, 2);
        set_duty(5, 10);
        set_map(13, 5, 1'b1);
        measure(13, hi, lo);
        check_eq("R2 gen5/ch13 high time", hi, exp_hi(10, 2));
        check_eq("R2 gen5/ch13 low time", lo, exp_lo(10, 2));

        // R3/R7: random configurations checked against computed timing
        for (int k = 0; k < 5; k++) begin
            g = $urandom_range(2, 7);
            c = $urandom_range(2, 12);
            p = $urandom_range(1, 3);
            d = $urandom_range(1, 254);
            set_period(g, p);
            set_duty(g, d);
            set_map(c, g, 1'b1);
            measure(c, hi, lo);
            check_eq($sformatf("R3 random high g%0d p%0d d%0d", g, p, d), hi, exp_hi(d, p));
            check_eq($sformatf("R3 random low g%0d p%0d d%0d", g, p, d), lo, exp_lo(d, p));
            set_map(c, g, 1'b0);
        end

        // R7: two channels sharing one generator stay identical
        set_period(6, 1);
        set_duty(6, 77);
        set_map(14, 6, 1'b1);
        set_map(15, 6, 1'b1);
        mism = 0;
        hi = 0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk);
            if (ch_out[14] != ch_out[15]) mism++;
            if (ch_out[14]) hi++;
        end
        check_eq("R7 shared channels mismatch count", mism, 0);
        check_eq("R7 shared channel high samples", (hi > 0) ? 1 : 0, 1);

        // R5: period 0 behaves as 1
        set_period(7, 0);
        set_duty(7, 3);
        set_map(12, 7, 1'b1);
        measure(12, hi, lo);
        check_eq("R5 period 0 high time", hi, exp_hi(3, 0));
        check_eq("R5 period 0 low time", lo, exp_lo(3, 0));

        // R5: period 255 behaves as 250 (switched right after a wrap)
        set_period(7, 1);
        set_duty(7, 1);
        wait_rise(12);
        set_period(7, 255);
        hi = 1;
        while (ch_out[12]) begin hi++; @(negedge clk); end
        check_eq("R5 period 255 clamped step length", hi, 250 * TICK_DIV);
        set_map(12, 7, 1'b0);

        // R9: clear landing on the wrap edge takes effect at that wrap
        set_period(3, 1);
        set_duty(3, 1);
        set_map(8, 3, 1'b1);
        set_map(9, 3, 1'b1);
        wait_rise(8);
        repeat (FULL_P1 - 1) @(negedge clk);
        set_map(9, 3, 1'b0);
        check_eq("R9 wrap-edge clear: reference high", int'(ch_out[8]), 1);
        check_eq("R9 wrap-edge clear: channel low", int'(ch_out[9]), 0);
        count_high(9, 1100, hi);
        check_eq("R9 wrap-edge clear stays low", hi, 0);

        // R9: clear one cycle after wrap keeps the rest of the pulse
        set_map(9, 3, 1'b1);
        wait_rise(8);
        repeat (FULL_P1) @(negedge clk);
        set_map(9, 3, 1'b0);
        check_eq("R9 late clear: still high", int'(ch_out[9]), 1);
        count_high(9, 1100, hi);
        check_eq("R9 late clear: remaining high samples", hi, TICK_DIV - 2);

        // R10: re-enable before wrap cancels the pending disable
        set_map(9, 3, 1'b1);
        wait_rise(8);
        set_map(9, 3, 1'b0);
        set_map(9, 3, 1'b1);
        measure(9, hi2, lo);
        check_eq("R10 cancelled disable high time", hi2, exp_hi(1, 1));
        check_eq("R10 cancelled disable low time", lo, exp_lo(1, 1));

        summary();
        $finish;
    end

endmodule